// File: doc/BRIEF.md
# Glitch-Free Dual RAM Bank Swapper

This block decides, on every cycle, which of two RAM banks (A and B) the probe processor may use and which one the target-side ROM emulation port may use. No bank ever has two owners. While a swap is under way, a bank may have no owner at all. The block keeps two state bits in series: a stage bit and a commit bit. In normal operation, the commit bit names the bank that the target holds, and the probe holds the other bank.

A swap takes two active bus cycles. On the first active bus cycle, the stage bit flips. The two bits now disagree, so the probe loses access to both banks while the target keeps the bank it had. On the next active bus cycle, the commit bit copies the stage bit, and the two banks change owners.

There are two ways to start a swap:
- **Immediate mode:** the swap starts on the next active bus cycle while the request is high.
- **Synchronized mode:** the swap also needs the sync-counter pulse, and it only starts once run mode is active.

Two force inputs override the swap state. They act combinationally and give a bank to the probe directly.

Top module: `bank_swapper`

## Requirements
- R1: When `force_a` and `force_b` are both high, `probe_own` is 2'b11 and `tgt_own` is 2'b00, whatever the swap state. In both own vectors, bit 0 is bank A and bit 1 is bank B.
- R2: When exactly one force input is high, the forced bank's bit is set in `probe_own` and the other bank's bit is set in `tgt_own`. No other bits are set.
- R3: With no force input high and no swap pending, `tgt_own` selects the bank named by the commit bit (0 = bank A, 1 = bank B). `probe_own` selects the other bank. No bank ever appears in both vectors.
- R4: In immediate mode (`swap_mode` = 0), a rising clock edge with `cyc_en` and `swap_req` high starts a swap. From the next cycle, with no force input high:
  - `busy` is high;
  - `probe_own` is 2'b00;
  - `tgt_own` is unchanged.
- R5: The next rising edge with `cyc_en` high after a swap has started ends it. `busy` falls, and the ownership of both banks is exchanged.
- R6: In synchronized mode (`swap_mode` = 1), a swap starts only on an edge where `cyc_en`, `swap_req`, `sync_pulse` and `run_mode` are all high.
- R7: A swap request seen while `busy` is high has no effect. The edge that ends the swap does not start another one.
- R8: Edges with `cyc_en` low change neither state bit. A pending swap stays pending.
- R9: `busy` is high exactly when the stage and commit bits disagree.
- R10: Synchronous reset clears both state bits. After reset, the target owns bank A, the probe owns bank B, and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Bus-cycle qualifier; the state advances only on edges where this is high |
| swap_req | input | 1 | Swap request level |
| swap_mode | input | 1 | 0 = immediate, 1 = synchronized to sync pulse and run mode |
| sync_pulse | input | 1 | Sync-counter output used in synchronized mode |
| run_mode | input | 1 | High while the target is running |
| force_a | input | 1 | Probe takes bank A directly |
| force_b | input | 1 | Probe takes bank B directly |
| probe_own | output | 2 | Banks owned by the probe (bit 0 = A, bit 1 = B) |
| tgt_own | output | 2 | Banks owned by the target port (bit 0 = A, bit 1 = B) |
| busy | output | 1 | A swap is between its two steps |

## Verification
The bench goes after the interval between the two steps of a swap. A design that commits in one step would never show `probe_own` at 2'b00. A design that drops the target's bank during that interval would cut the target off in the middle of a run.

It holds a request high across the commit edge. A design that does not ignore requests while busy would flip the stage bit again and never settle.

It holds `cyc_en` low while a swap is pending. A design that advances on every clock would complete the swap too early.

It also tries synchronized mode with each qualifier missing, and it applies forces during a swap, where a wrong override order would hand a bank to both sides.

// File: rtl/bswap_pkg.sv
package bswap_pkg;

    localparam int NBANK = 2;

    typedef enum logic {
        MODE_NOW  = 1'b0,
        MODE_SYNC = 1'b1
    } swap_mode_e;

    typedef struct packed {
        logic stage;
        logic commit;
    } swap_st_t;

    typedef struct packed {
        logic probe;
        logic tgt;
    } bank_own_t;

    // Ownership of one bank given its own force, the other bank's force,
    // whether a swap is mid-way and whether the commit bit names this bank.
    function automatic bank_own_t route_bank(
        input logic forced_self,
        input logic forced_other,
        input logic mid_swap,
        input logic commit_here
    );
        bank_own_t r;
        r.probe = forced_self | (~forced_other & ~mid_swap & ~commit_here);
        r.tgt   = ~forced_self & (forced_other | commit_here);
        return r;
    endfunction

endpackage

// File: rtl/bswap_trigger.sv
module bswap_trigger
    import bswap_pkg::*;
(
    input  logic       cyc_en,
    input  logic       req,
    input  swap_mode_e mode,
    input  logic       sync_pulse,
    input  logic       run_mode,
    input  logic       mid_swap,
    output logic       start
);
    logic qualified;

    always_comb begin
        unique case (mode)
            MODE_NOW:  qualified = 1'b1;
            MODE_SYNC: qualified = sync_pulse & run_mode;
            default:   qualified = 1'b0;
        endcase
        start = cyc_en & req & ~mid_swap & qualified;
    end
endmodule

// File: rtl/bswap_stages.sv
module bswap_stages
    import bswap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cyc_en,
    input  logic     start,
    output swap_st_t st,
    output logic     mid_swap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (cyc_en) begin
            if (st.stage != st.commit) begin
                st.commit <= st.stage;
            end else if (start) begin
                st.stage <= ~st.stage;
            end
        end
    end

    assign mid_swap = st.stage ^ st.commit;
endmodule

// File: rtl/bswap_route.sv
module bswap_route
    import bswap_pkg::*;
(
    input  logic [NBANK-1:0] forced,
    input  swap_st_t         st,
    input  logic             mid_swap,
    output logic [NBANK-1:0] probe_own,
    output logic [NBANK-1:0] tgt_own
);
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        bank_own_t own;
        logic      here;
        assign here = (i == 0) ? ~st.commit : st.commit;
        assign own  = route_bank(forced[i], forced[NBANK-1-i], mid_swap, here);
        assign probe_own[i] = own.probe;
        assign tgt_own[i]   = own.tgt;
    end
endmodule

// File: rtl/bank_swapper.sv
module bank_swapper
    import bswap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_en,
    input  logic       swap_req,
    input  logic       swap_mode,
    input  logic       sync_pulse,
    input  logic       run_mode,
    input  logic       force_a,
    input  logic       force_b,
    output logic [1:0] probe_own,
    output logic [1:0] tgt_own,
    output logic       busy
);
    swap_st_t   st;
    logic       mid_swap;
    logic       start;
    swap_mode_e mode;

    assign mode = swap_mode_e'(swap_mode);

    bswap_trigger u_trig (
        .cyc_en     (cyc_en),
        .req        (swap_req),
        .mode       (mode),
        .sync_pulse (sync_pulse),
        .run_mode   (run_mode),
        .mid_swap   (mid_swap),
        .start      (start)
    );

    bswap_stages u_stages (
        .clk      (clk),
        .rst      (rst),
        .cyc_en   (cyc_en),
        .start    (start),
        .st       (st),
        .mid_swap (mid_swap)
    );

    bswap_route u_route (
        .forced    ({force_b, force_a}),
        .st        (st),
        .mid_swap  (mid_swap),
        .probe_own (probe_own),
        .tgt_own   (tgt_own)
    );

    assign busy = mid_swap;
endmodule

// File: rtl/bswap_checker.sv
module bswap_checker (
    input logic       clk,
    input logic       rst,
    input logic       cyc_en,
    input logic       swap_req,
    input logic       swap_mode,
    input logic       sync_pulse,
    input logic       run_mode,
    input logic       force_a,
    input logic       force_b,
    input logic [1:0] probe_own,
    input logic [1:0] tgt_own,
    input logic       busy
);
    // R1
    a_r1_both_forced: assert property (@(posedge clk) disable iff (rst)
        (force_a && force_b) |-> (probe_own == 2'b11 && tgt_own == 2'b00));

    // R3
    a_r3_no_shared_bank: assert property (@(posedge clk) disable iff (rst)
        (probe_own & tgt_own) == 2'b00);

    // R4
    a_r4_probe_locked_out: assert property (@(posedge clk) disable iff (rst)
        (busy && !force_a && !force_b) |-> (probe_own == 2'b00 && $countones(tgt_own) == 1));

    a_r4_now_starts: assert property (@(posedge clk) disable iff (rst)
        (!busy && cyc_en && swap_req && !swap_mode) |=> busy);

    // R5
    a_r5_commit_next: assert property (@(posedge clk) disable iff (rst)
        (busy && cyc_en) |=> !busy);

    // R6
    a_r6_sync_gated: assert property (@(posedge clk) disable iff (rst)
        (!busy && cyc_en && swap_mode && !(sync_pulse && run_mode)) |=> !busy);

    // R8
    a_r8_hold_off_cycle: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> $stable(busy));

    // R2
    a_r2_single_force: assert property (@(posedge clk) disable iff (rst)
        (force_a ^ force_b) |-> ($onehot0(probe_own) && $countones(tgt_own) == 1
                                 && (probe_own | tgt_own) == 2'b11));
endmodule

bind bank_swapper bswap_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_en     (cyc_en),
    .swap_req   (swap_req),
    .swap_mode  (swap_mode),
    .sync_pulse (sync_pulse),
    .run_mode   (run_mode),
    .force_a    (force_a),
    .force_b    (force_b),
    .probe_own  (probe_own),
    .tgt_own    (tgt_own),
    .busy       (busy)
);

// File: tb/sim_bank_swapper.sv
module sim_bank_swapper;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b0;
    logic       swap_req = 1'b0;
    logic       swap_mode = 1'b0;
    logic       sync_pulse = 1'b0;
    logic       run_mode = 1'b0;
    logic       force_a = 1'b0;
    logic       force_b = 1'b0;
    logic [1:0] probe_own;
    logic [1:0] tgt_own;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int m_stage = 0;   // reference: stage bit
    int m_commit = 0;  // reference: commit bit
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    bank_swapper u0 (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .swap_req(swap_req),
        .swap_mode(swap_mode), .sync_pulse(sync_pulse), .run_mode(run_mode),
        .force_a(force_a), .force_b(force_b),
        .probe_own(probe_own), .tgt_own(tgt_own), .busy(busy)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (probe,tgt,busy)", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] model_out();
        logic [1:0] p, t;
        logic b;
        b = (m_stage != m_commit);
        if (force_a && force_b) begin p = 2'b11; t = 2'b00; end
        else if (force_a)       begin p = 2'b01; t = 2'b10; end
        else if (force_b)       begin p = 2'b10; t = 2'b01; end
        else begin
            t = (m_commit != 0) ? 2'b10 : 2'b01;
            p = b ? 2'b00 : ~t;
        end
        return {p, t, b};
    endfunction

    function automatic string model_tag();
        if (force_a && force_b) return "R1";
        if (force_a || force_b) return "R2";
        if (m_stage != m_commit) return "R4";
        return "R3";
    endfunction

    // one clock: reference advances on the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        cycles++;
        if (rst) begin
            m_stage = 0; m_commit = 0;
        end else if (cyc_en) begin
            if (m_stage != m_commit) m_commit = m_stage;
            else if (swap_req && (!swap_mode || (sync_pulse && run_mode)))
                m_stage = 1 - m_stage;
        end
        @(negedge clk);
        chk(model_tag(), {probe_own, tgt_own, busy}, model_out());
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R10 reset owners", {probe_own, tgt_own, busy}, 5'b10_01_0);

        // immediate swap
        cyc_en = 1; swap_req = 1; tick();
        swap_req = 0;
        chk("R4 probe locked out, target keeps A", {probe_own, tgt_own, busy}, 5'b00_01_1);
        chk("R9 busy mid-swap", {4'b0, busy}, 5'b00001);
        cyc_en = 0; tick(); tick();
        chk("R8 pending held without cyc_en", {probe_own, tgt_own, busy}, 5'b00_01_1);
        cyc_en = 1; tick();
        chk("R5 exchange committed", {probe_own, tgt_own, busy}, 5'b01_10_0);

        // request held across the commit edge
        swap_req = 1; tick();
        chk("R4 second swap start", {probe_own, tgt_own, busy}, 5'b00_10_1);
        tick();
        chk("R7 request ignored on commit edge", {probe_own, tgt_own, busy}, 5'b10_01_0);
        tick(); swap_req = 0; tick();
        chk("R5 back to target B", {probe_own, tgt_own, busy}, 5'b01_10_0);

        // synchronized mode
        swap_mode = 1; swap_req = 1; sync_pulse = 1; run_mode = 0; tick(); tick();
        chk("R6 no run mode no swap", {probe_own, tgt_own, busy}, 5'b01_10_0);
        sync_pulse = 0; run_mode = 1; tick();
        chk("R6 no sync pulse no swap", {probe_own, tgt_own, busy}, 5'b01_10_0);
        sync_pulse = 1; tick();
        sync_pulse = 0; swap_req = 0;
        chk("R6 qualified swap starts", {probe_own, tgt_own, busy}, 5'b00_10_1);

        // forces in the middle of a swap
        cyc_en = 0; force_a = 1; tick();
        chk("R2 force A mid-swap", {probe_own, tgt_own, busy}, 5'b01_10_1);
        force_a = 0; force_b = 1; tick();
        chk("R2 force B mid-swap", {probe_own, tgt_own, busy}, 5'b10_01_1);
        force_a = 1; tick();
        chk("R1 both forced", {probe_own, tgt_own, busy}, 5'b11_00_1);
        force_a = 0; force_b = 0; cyc_en = 1; tick();
        chk("R5 commit after forces", {probe_own, tgt_own, busy}, 5'b10_01_0);

        // mixed stimulus against the reference model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            cyc_en = r[0] | r[1];
            swap_req = r[2];
            swap_mode = r[3];
            sync_pulse = r[4];
            run_mode = r[5] | r[6];
            force_a = (r[9:7] == 3'd0);
            force_b = (r[12:10] == 3'd0);
            rst = (r[20:13] == 8'd0);
            tick();
        end
        rst = 1; tick(); rst = 0; force_a = 0; force_b = 0; cyc_en = 0; tick();
        chk("R10 reset after traffic", {probe_own, tgt_own, busy}, 5'b10_01_0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule